// File: doc/BRIEF.md
# Edge-Triggered Wake-Up Controller

This block watches sixteen groups of eight input lines and records, per line, whether a selected transition has occurred. Every line passes through a two-flop synchroniser. The synchronised level is compared with its value one cycle earlier to find transitions. A transition that matches the line's edge selection sets a sticky event bit. The bit stays set until software clears it by writing a one to it.

Each line can be configured for rising, falling or both edges. A per-line enable decides whether a recorded event takes part in the single wake-up request sent to power management. Only three groups have an enable byte. In the other groups every line is permanently enabled.

Software uses a byte-wide register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `wuc_wake_ctrl`

## Requirements
- R1: After reset, every configuration byte and every event bit reads 0, and `wake_req` is low. With all bytes at 0, every line is in rising-edge mode.
- R2: Groups 1 to 4 (index n = 0..3) place their bytes at these addresses:
  - edge select byte at 0x00+n
  - event byte at 0x04+n
  - enable byte at 0x08+n
  - both-edge byte at 0x3C+n
- R3: Group k (5..16) owns the window at 0x0C+4*(k-5):
  - edge select byte at +0
  - event byte at +1
  - both-edge byte at +3
  - The slot at +2 and all addresses above 0x3F read 0. Writes to them change nothing.
- R4: When a line's both-edge bit is 0, its edge select bit chooses the transition: 0 detects a rise and 1 detects a fall. The opposite transition is ignored.
- R5: When a line's both-edge bit is 1, the line detects rises and falls, whatever its edge select bit holds.
- R6: An event bit, once set, stays set until software clears it. Further transitions and configuration writes do not clear it.
- R7: Writing the event byte clears each bit written as 1. Bits written as 0 keep their value.
- R8: If a detected transition and a clearing write for the same bit land on the same clock edge, the bit ends up set.
- R9: Only groups 1, 3 and 4 have a writable enable byte. The enable address of every other group (including group 2 at 0x09) reads 0 and ignores writes, and those groups' lines are always enabled.
- R10: `wake_req` is high exactly when some event bit is set and its line is enabled. A set event bit on a disabled line does not raise `wake_req`.
- R11: A level change on an input that is held steady is visible in the event byte after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | 128 | Input lines; group g (0-based) uses bits 8g+7..8g |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed byte (combinational) |
| wake_req | output | 1 | Combined wake-up request |

## Verification
A corrupted edge select or both-edge bit reads back wrong at once. It also shows as a missing or extra event bit about three cycles after the next input change. A lost or spurious event bit shows in the event byte read right after the synchroniser latency. It also shows on `wake_req` in the same cycle whenever the line is enabled. Decode faults appear as a byte that lands in, or reads from, the wrong group on the first access to it. Random traffic of input changes, configuration writes and clears is mixed with directed cases for the same-edge clear race and the exact latency.

// File: rtl/wuc_pkg.sv
package wuc_pkg;

    localparam int GRP_W      = 8;
    localparam int NUM_GRP    = 16;
    localparam int GRP_IDX_W  = $clog2(NUM_GRP);
    localparam int ADDR_W     = 8;
    localparam int LOW_GRPS   = 4;
    localparam logic [ADDR_W-1:0] WIN_BASE  = 8'h0C;
    localparam logic [ADDR_W-1:0] BOTH_BASE = 8'h3C;

    typedef logic [GRP_W-1:0] byte_t;

    typedef enum logic [1:0] {
        K_MODE = 2'd0,
        K_STAT = 2'd1,
        K_EN   = 2'd2,
        K_BOTH = 2'd3
    } reg_kind_e;

    typedef struct packed {
        byte_t mode;
        byte_t stat;
        byte_t en;
        byte_t both;
    } grp_regs_t;

    typedef struct packed {
        logic mode;
        logic stat;
        logic en;
        logic both;
    } grp_wr_t;

    typedef struct packed {
        logic                 hit;
        logic [GRP_IDX_W-1:0] grp;
        reg_kind_e            kind;
    } dec_t;

    // Address decode of the fixed byte map
    function automatic dec_t wuc_decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        logic [ADDR_W-1:0] off;
        d.hit  = 1'b0;
        d.grp  = '0;
        d.kind = K_MODE;
        off    = a - WIN_BASE;
        if (a < WIN_BASE) begin
            d.hit  = 1'b1;
            d.grp  = GRP_IDX_W'(a[1:0]);
            d.kind = reg_kind_e'(a[3:2]);
        end else if (a >= BOTH_BASE && a <= BOTH_BASE + 8'd3) begin
            d.hit  = 1'b1;
            d.grp  = GRP_IDX_W'(a[1:0]);
            d.kind = K_BOTH;
        end else if (a < BOTH_BASE) begin
            d.grp = GRP_IDX_W'(LOW_GRPS) + GRP_IDX_W'(off[5:2]);
            case (off[1:0])
                2'd0:    begin d.hit = 1'b1; d.kind = K_MODE; end
                2'd1:    begin d.hit = 1'b1; d.kind = K_STAT; end
                2'd3:    begin d.hit = 1'b1; d.kind = K_BOTH; end
                default: d.hit = 1'b0;
            endcase
        end
        return d;
    endfunction

    // Per-line detection for one byte of lines
    function automatic byte_t edge_match(input byte_t cur, input byte_t old,
                                         input byte_t mode, input byte_t both);
        byte_t rise;
        byte_t fall;
        rise = cur & ~old;
        fall = ~cur & old;
        return (both & (rise | fall)) | (~both & ((mode & fall) | (~mode & rise)));
    endfunction

endpackage

// File: rtl/wuc_sync.sv
module wuc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wuc_group.sv
module wuc_group
    import wuc_pkg::*;
#(
    parameter bit HAS_EN      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  byte_t     pins,
    input  grp_wr_t   wr,
    input  byte_t     wdata,
    output grp_regs_t regs,
    output logic      wake
);
    byte_t lvl, prev_q, edge_hit;
    byte_t mode_q, stat_q, both_q, en_q, eff_en;

    wuc_sync #(.W(GRP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pins), .q(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign edge_hit = edge_match(lvl, prev_q, mode_q, both_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            both_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr.mode) mode_q <= wdata;
            if (wr.both) both_q <= wdata;
            // new event wins over a same-edge clear
            stat_q <= (stat_q & ~(wr.stat ? wdata : '0)) | edge_hit;
        end
    end

    generate
        if (HAS_EN) begin : g_en
            always_ff @(posedge clk) begin
                if (rst)        en_q <= '0;
                else if (wr.en) en_q <= wdata;
            end
            assign eff_en = en_q;
        end else begin : g_no_en
            assign en_q   = '0;
            assign eff_en = '1;
        end
    endgenerate

    assign wake = |(stat_q & eff_en);

    always_comb begin
        regs.mode = mode_q;
        regs.stat = stat_q;
        regs.en   = en_q;
        regs.both = both_q;
    end

    // R6
    stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_hit) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.stat) |=> ((stat_q & $past(wdata & ~edge_hit)) == '0));

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr.stat && edge_hit == '0) |=> $stable(stat_q));
endmodule

// File: rtl/wuc_regif.sv
module wuc_regif
    import wuc_pkg::*;
(
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  grp_regs_t [NUM_GRP-1:0]   regs,
    output grp_wr_t   [NUM_GRP-1:0]   wr_str,
    output byte_t                     reg_rdata
);
    dec_t dec;
    assign dec = wuc_decode(reg_addr);

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_str
            logic sel;
            assign sel            = reg_wr && dec.hit && (dec.grp == GRP_IDX_W'(g));
            assign wr_str[g].mode = sel && (dec.kind == K_MODE);
            assign wr_str[g].stat = sel && (dec.kind == K_STAT);
            assign wr_str[g].en   = sel && (dec.kind == K_EN);
            assign wr_str[g].both = sel && (dec.kind == K_BOTH);
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (dec.hit) begin
            case (dec.kind)
                K_MODE:  reg_rdata = regs[dec.grp].mode;
                K_STAT:  reg_rdata = regs[dec.grp].stat;
                K_EN:    reg_rdata = regs[dec.grp].en;
                default: reg_rdata = regs[dec.grp].both;
            endcase
        end
    end
endmodule

// File: rtl/wuc_wake_ctrl.sv
module wuc_wake_ctrl
    import wuc_pkg::*;
#(
    parameter logic [NUM_GRP-1:0] GRP_HAS_EN  = 16'h000D,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_GRP*GRP_W-1:0] wake_in,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [GRP_W-1:0]         reg_wdata,
    output logic [GRP_W-1:0]         reg_rdata,
    output logic                     wake_req
);
    localparam int CFG_W = 3 * GRP_W;

    grp_regs_t [NUM_GRP-1:0] regs;
    grp_wr_t   [NUM_GRP-1:0] wr_str;
    logic      [NUM_GRP-1:0] grp_wake;
    logic [NUM_GRP*CFG_W-1:0] cfg_all;
    dec_t top_dec;

    wuc_regif u_regif (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .regs(regs),
        .wr_str(wr_str), .reg_rdata(reg_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            wuc_group #(.HAS_EN(GRP_HAS_EN[g]), .SYNC_STAGES(SYNC_STAGES)) u_grp (
                .clk(clk), .rst(rst),
                .pins(wake_in[g*GRP_W +: GRP_W]),
                .wr(wr_str[g]), .wdata(reg_wdata),
                .regs(regs[g]), .wake(grp_wake[g])
            );
            assign cfg_all[g*CFG_W +: CFG_W] = {regs[g].mode, regs[g].en, regs[g].both};
        end
    endgenerate

    assign wake_req = |grp_wake;
    assign top_dec  = wuc_decode(reg_addr);

    // R3
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !top_dec.hit) |=> $stable(cfg_all));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!wake_req && cfg_all == '0));
endmodule

// File: tb/test_wuc_wake_ctrl.sv
`timescale 1ns/1ps
module test_wuc_wake_ctrl;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] wake_in = '0;
    logic [7:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;
    logic         wake_req;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_mode [16];
    logic [7:0] m_stat [16];
    logic [7:0] m_en   [16];
    logic [7:0] m_both [16];

    always #2.5 clk = ~clk;

    wuc_wake_ctrl i_wuc_wake_ctrl (
        .clk(clk), .rst(rst), .wake_in(wake_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_req(wake_req)
    );

    function automatic bit has_en(int g);
        return (g == 0) || (g == 2) || (g == 3);
    endfunction

    // kind: 0 edge select, 1 event, 2 enable, 3 both-edge (R2, R3)
    function automatic logic [7:0] a_of(int kind, int g);
        if (g < 4) begin
            case (kind)
                0: return 8'(g);
                1: return 8'(4 + g);
                2: return 8'(8 + g);
                default: return 8'(60 + g);
            endcase
        end
        return 8'(12 + 4 * (g - 4) + kind);
    endfunction

    function automatic logic [7:0] hits(logic [7:0] o, logic [7:0] n, logic [7:0] md, logic [7:0] bo);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            if (bo[b])      r[b] = o[b] ^ n[b];
            else if (md[b]) r[b] = o[b] & ~n[b];
            else            r[b] = ~o[b] & n[b];
        end
        return r;
    endfunction

    function automatic logic exp_wake();
        logic w = 1'b0;
        for (int g = 0; g < 16; g++)
            w |= |(m_stat[g] & (has_en(g) ? m_en[g] : 8'hFF));
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cfg(int kind, int g, logic [7:0] d);
        wr_reg(a_of(kind, g), d);
        case (kind)
            0: m_mode[g] = d;
            1: m_stat[g] &= ~d;
            2: if (has_en(g)) m_en[g] = d;
            default: m_both[g] = d;
        endcase
    endtask

    task automatic apply_in(logic [127:0] nv);
        @(negedge clk);
        for (int g = 0; g < 16; g++)
            m_stat[g] |= hits(wake_in[g*8 +: 8], nv[g*8 +: 8], m_mode[g], m_both[g]);
        wake_in = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_grp(string req, int g);
        logic [7:0] d;
        rd_reg(a_of(1, g), d);
        check(req, d, m_stat[g]);
        check("R10", wake_req, exp_wake());
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic [127:0] nv;
        void'($urandom(32'd4242));
        for (int g = 0; g < 16; g++) begin
            m_mode[g] = '0; m_stat[g] = '0; m_en[g] = '0; m_both[g] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int g = 0; g < 16; g++)
            for (int k = 0; k < 4; k++) begin
                rd_reg(a_of(k, g), d);
                check("R1", d, 8'h00);
            end
        check("R1", wake_req, 1'b0);

        // R3: unused slot and out-of-map addresses
        wr_reg(8'h0E, 8'hFF);
        rd_reg(8'h0E, d); check("R3", d, 8'h00);
        wr_reg(8'h50, 8'hFF);
        rd_reg(8'h50, d); check("R3", d, 8'h00);

        // R2/R3: map placement readback
        cfg(0, 1, 8'hA5); rd_reg(8'h01, d); check("R2", d, 8'hA5);
        cfg(3, 2, 8'h3C); rd_reg(8'h3E, d); check("R2", d, 8'h3C);
        cfg(0, 5, 8'h5A); rd_reg(8'h10, d); check("R3", d, 8'h5A);
        cfg(3, 15, 8'h81); rd_reg(8'h3B, d); check("R3", d, 8'h81);
        cfg(0, 1, 8'h00); cfg(3, 2, 8'h00); cfg(0, 5, 8'h00); cfg(3, 15, 8'h00);

        // R9: group 2 enable absent, always enabled
        wr_reg(8'h09, 8'hFF);
        rd_reg(8'h09, d); check("R9", d, 8'h00);

        // R11: latency on group 2 line 0 (rising)
        @(negedge clk);
        wake_in[8] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_reg(a_of(1, 1), d); check("R11", d, 8'h00);
        @(negedge clk);
        rd_reg(a_of(1, 1), d); check("R11", d, 8'h01);
        m_stat[1] = 8'h01;
        check("R9", wake_req, 1'b1);
        cfg(1, 1, 8'h01); chk_grp("R7", 1);

        // R4: falling selected on group 1 line 1, rise ignored
        cfg(0, 0, 8'h02);
        nv = wake_in; nv[1] = 1'b1; apply_in(nv); chk_grp("R4", 0);
        nv[1] = 1'b0; apply_in(nv); chk_grp("R4", 0);
        // R10: group 1 disabled, event set, no wake
        check("R10", wake_req, 1'b0);
        cfg(2, 0, 8'h02); check("R10", wake_req, 1'b1);
        // R7: write 0 keeps bit, write 1 clears
        cfg(1, 0, 8'h00); chk_grp("R7", 0);
        cfg(1, 0, 8'h02); chk_grp("R7", 0);

        // R5: both-edge overrides edge select
        cfg(0, 6, 8'h01); cfg(3, 6, 8'h01);
        nv = wake_in; nv[48] = 1'b1; apply_in(nv); chk_grp("R5", 6);
        cfg(1, 6, 8'h01);
        nv[48] = 1'b0; apply_in(nv); chk_grp("R5", 6);
        cfg(1, 6, 8'h01);

        // R8: edge and clear on the same clock edge
        cfg(0, 3, 8'h00); cfg(3, 3, 8'h00);
        @(negedge clk);
        wake_in[24] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = a_of(1, 3); reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        m_stat[3] |= 8'h01;
        chk_grp("R8", 3);
        cfg(1, 3, 8'h01); chk_grp("R7", 3);

        // Random traffic: R4 R5 R6 R7 R9 R10
        for (int it = 0; it < 500; it++) begin
            int act = $urandom % 4;
            int g   = $urandom % 16;
            case (act)
                0: begin
                    nv = wake_in;
                    for (int w = 0; w < 4; w++) nv[w*32 +: 32] ^= $urandom & $urandom;
                    apply_in(nv);
                end
                1: cfg($urandom % 2 == 0 ? 0 : 3, g, 8'($urandom));
                2: cfg(2, g, 8'($urandom));
                default: cfg(1, g, 8'($urandom));
            endcase
            chk_grp("R6", $urandom % 16);
            if (act == 2) begin
                rd_reg(a_of(2, g), d); check("R9", d, m_en[g]);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule